// File: doc/BRIEF.md
# Clock Lane Start/Stop Sequencer

This block drives the power state of a unidirectional serial clock lane, which only the transmitting side ever drives. While idle the lane rests in the low-power stop level, with both wires high. A rising run request starts a timed walk through the low-power entry levels into the high-speed zero level. The sequencer then switches on the toggling high-speed clock. After a programmed number of toggling cycles it raises a grant. The grant is the acknowledge of the run request and tells the data lane that its burst may start.

When the requester has dropped its request and the data lane reports that it is back in its stop state, the sequencer removes the grant. It keeps the clock toggling for a programmed tail, then holds the high-speed zero level for a trail interval, and finally returns the lane to the stop level. From the stop level the lane can also be parked in an ultra-low-power state and woken again. Beyond that parked state the clock lane has no escape sequences.

Each interval is a cycle count. The counts are taken from configuration inputs while reset is held and stay fixed until the next reset. The block produces lane state outputs only. Serialisation and the analog drivers lie outside it.

Top module: `clk_lane_seq`

## Requirements
- R1: While reset is held and in the first cycle after release, lane_lp is 2'b11 (bit 1 is the P wire, bit 0 the N wire), and lane_hs, clk_toggle, data_grant and lane_ulps are all 0.
- R2: A run request seen in the stop state produces this sequence: lane_lp=2'b01 for the low-power request count, then lane_lp=2'b00 for the prepare count, then lane_hs=1 with clk_toggle=0 (high-speed zero) for the zero count, then clk_toggle=1.
- R3: data_grant rises only after clk_toggle has been 1 with the grant low for exactly the pre count. From then on it stays 1 while the clock keeps toggling.
- R4: With data_grant at 1, run_req at 0 and data_stop at 1 on a clock edge, data_grant falls at that edge. clk_toggle then stays 1 for the post count. After that, high-speed zero is held for the trail count, and then the lane returns to lane_lp=2'b11 with lane_hs at 0.
- R5: While data_grant is 1, wind-down does not begin as long as run_req is 1 or data_stop is 0.
- R6: ulps_req seen in the stop state with no run request drives lane_lp=2'b10 for the low-power request count. The lane then enters lane_lp=2'b00 with lane_ulps=1 and stays there while ulps_req stays 1.
- R7: When ulps_req falls in the ultra-low-power state, lane_lp=2'b10 is driven with lane_ulps=0 for the wake count, and then lane_lp=2'b11.
- R8: A run request raised during the ultra-low-power state changes nothing until the wake exit finishes. The lane then spends one cycle at 2'b11 and starts the R2 sequence.
- R9: If run_req and ulps_req are both 1 in the stop state, the start sequence wins.
- R10: Interval counts are sampled from the cfg inputs only while rst_n is 0. Changing the cfg inputs afterwards has no effect on any interval.
- R11: A count of zero acts as a count of one.
- R12: clk_toggle=1 implies lane_hs=1, and lane_hs=1 implies lane_lp=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; interval counts are captured while low |
| cfg_lpx | input | CW | Low-power request level count (also used for ULPS entry) |
| cfg_prep | input | CW | Prepare (LP-00) count |
| cfg_zero | input | CW | High-speed zero count before toggling |
| cfg_pre | input | CW | Toggling cycles before the grant |
| cfg_post | input | CW | Toggling cycles after the grant is removed |
| cfg_trail | input | CW | High-speed zero count after toggling stops |
| cfg_wake | input | CW | LP-10 count on ULPS exit |
| run_req | input | 1 | Clock run request |
| data_stop | input | 1 | Data lane is in its stop state |
| ulps_req | input | 1 | Ultra-low-power request |
| lane_lp | output | 2 | Low-power wire levels {P, N} |
| lane_hs | output | 1 | High-speed drivers enabled |
| clk_toggle | output | 1 | High-speed clock toggling |
| data_grant | output | 1 | Data lane may burst; acknowledge of run_req |
| lane_ulps | output | 1 | Lane parked in the ultra-low-power state |

## Verification
A wrong state or a miscounted interval shows up within one cycle as a level run on lane_lp, lane_hs, clk_toggle or data_grant that is one cycle too long or too short, or as a level appearing out of order. The bench therefore records every cycle of each sequence and compares it against run lengths computed from the configured counts. It sweeps all small count combinations. A grant that stays stuck or a missed wind-down shows up at the first edge where the stop condition holds.

// File: rtl/clk_lane_seq.sv
module clk_lane_seq #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_lpx,
  input  logic [CW-1:0] cfg_prep,
  input  logic [CW-1:0] cfg_zero,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_post,
  input  logic [CW-1:0] cfg_trail,
  input  logic [CW-1:0] cfg_wake,
  input  logic          run_req,
  input  logic          data_stop,
  input  logic          ulps_req,
  output logic [1:0]    lane_lp,
  output logic          lane_hs,
  output logic          clk_toggle,
  output logic          data_grant,
  output logic          lane_ulps
);

  typedef enum logic [3:0] {
    S_STOP, S_REQ, S_PREP, S_ZERO, S_PRE, S_RUN,
    S_POST, S_TRAIL, S_UENT, S_ULPS, S_WAKE
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, lim;
  logic [CW-1:0] t_lpx, t_prep, t_zero, t_pre, t_post, t_trail, t_wake;
  logic done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_lpx   <= cfg_lpx;
      t_prep  <= cfg_prep;
      t_zero  <= cfg_zero;
      t_pre   <= cfg_pre;
      t_post  <= cfg_post;
      t_trail <= cfg_trail;
      t_wake  <= cfg_wake;
    end
  end

  always_comb begin
    case (st)
      S_REQ, S_UENT: lim = t_lpx;
      S_PREP:        lim = t_prep;
      S_ZERO:        lim = t_zero;
      S_PRE:         lim = t_pre;
      S_POST:        lim = t_post;
      S_TRAIL:       lim = t_trail;
      S_WAKE:        lim = t_wake;
      default:       lim = '0;
    endcase
  end

  assign done = (lim <= CW'(1)) || (cnt == lim - CW'(1));

  always_comb begin
    nxt = st;
    case (st)
      S_STOP:  if (run_req) nxt = S_REQ;
               else if (ulps_req) nxt = S_UENT;
      S_REQ:   if (done) nxt = S_PREP;
      S_PREP:  if (done) nxt = S_ZERO;
      S_ZERO:  if (done) nxt = S_PRE;
      S_PRE:   if (done) nxt = S_RUN;
      S_RUN:   if (!run_req && data_stop) nxt = S_POST;
      S_POST:  if (done) nxt = S_TRAIL;
      S_TRAIL: if (done) nxt = S_STOP;
      S_UENT:  if (done) nxt = S_ULPS;
      S_ULPS:  if (!ulps_req) nxt = S_WAKE;
      S_WAKE:  if (done) nxt = S_STOP;
      default: nxt = S_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_STOP;
      cnt <= '0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st) ? '0 : cnt + CW'(1);
    end
  end

  always_comb begin
    case (st)
      S_STOP:         lane_lp = 2'b11;
      S_REQ:          lane_lp = 2'b01;
      S_UENT, S_WAKE: lane_lp = 2'b10;
      default:        lane_lp = 2'b00;
    endcase
  end

  assign lane_hs    = st inside {S_ZERO, S_PRE, S_RUN, S_POST, S_TRAIL};
  assign clk_toggle = st inside {S_PRE, S_RUN, S_POST};
  assign data_grant = (st == S_RUN);
  assign lane_ulps  = (st == S_ULPS);

endmodule

// File: rtl/clk_lane_seq_chk.sv
module clk_lane_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_req,
  input logic       data_stop,
  input logic [1:0] lane_lp,
  input logic       lane_hs,
  input logic       clk_toggle,
  input logic       data_grant,
  input logic       lane_ulps
);

  a_r12_toggle_needs_hs: assert property (@(posedge clk) disable iff (!rst_n)
    clk_toggle |-> lane_hs);

  a_r12_hs_lp_low: assert property (@(posedge clk) disable iff (!rst_n)
    lane_hs |-> lane_lp == 2'b00);

  a_r3_grant_needs_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    data_grant |-> clk_toggle);

  a_r2_toggle_after_hs0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_toggle) |-> $past(lane_hs && !clk_toggle));

  a_r4_winddown: assert property (@(posedge clk) disable iff (!rst_n)
    (data_grant && !run_req && data_stop) |=> (!data_grant && clk_toggle));

  a_r5_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_grant && (run_req || !data_stop)) |=> data_grant);

  a_r6_ulps_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_ulps) |-> ($past(lane_lp == 2'b10) && lane_lp == 2'b00));

  a_r7_ulps_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lane_ulps) |-> lane_lp == 2'b10);

endmodule

bind clk_lane_seq clk_lane_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_req(run_req), .data_stop(data_stop),
  .lane_lp(lane_lp), .lane_hs(lane_hs), .clk_toggle(clk_toggle),
  .data_grant(data_grant), .lane_ulps(lane_ulps)
);

// File: tb/clk_lane_seq_bench.sv
module clk_lane_seq_bench;
  localparam int CW = 8;
  localparam logic [5:0] Y_STOP  = 6'b110000;
  localparam logic [5:0] Y_LP01  = 6'b010000;
  localparam logic [5:0] Y_LP00  = 6'b000000;
  localparam logic [5:0] Y_LP10  = 6'b100000;
  localparam logic [5:0] Y_HS0   = 6'b001000;
  localparam logic [5:0] Y_TOG   = 6'b001100;
  localparam logic [5:0] Y_GRANT = 6'b001110;
  localparam logic [5:0] Y_ULPS  = 6'b000001;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cfg_lpx, cfg_prep, cfg_zero, cfg_pre, cfg_post, cfg_trail, cfg_wake;
  logic run_req = 0, data_stop = 1, ulps_req = 0;
  logic [1:0] lane_lp;
  logic lane_hs, clk_toggle, data_grant, lane_ulps;
  logic [5:0] sym;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clk_lane_seq #(.CW(CW)) u_clk_lane_seq (
    .clk(clk), .rst_n(rst_n), .cfg_lpx(cfg_lpx), .cfg_prep(cfg_prep),
    .cfg_zero(cfg_zero), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
    .cfg_trail(cfg_trail), .cfg_wake(cfg_wake), .run_req(run_req),
    .data_stop(data_stop), .ulps_req(ulps_req), .lane_lp(lane_lp),
    .lane_hs(lane_hs), .clk_toggle(clk_toggle), .data_grant(data_grant),
    .lane_ulps(lane_ulps)
  );

  assign sym = {lane_lp, lane_hs, clk_toggle, data_grant, lane_ulps};

  task automatic chk(string tag, logic [5:0] exp);
    checks++;
    if (sym !== exp) begin
      errors++;
      $display("FAIL %s: lane state %b expected %b at %0t", tag, sym, exp, $time);
    end
  endtask

  task automatic expect_run(logic [5:0] exp, int len, string tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk(tag, exp);
    end
  endtask

  task automatic do_reset(int lpx, int prep, int zero, int pre, int post, int trail, int wake);
    cfg_lpx = CW'(lpx); cfg_prep = CW'(prep); cfg_zero = CW'(zero);
    cfg_pre = CW'(pre); cfg_post = CW'(post); cfg_trail = CW'(trail);
    cfg_wake = CW'(wake);
    run_req = 0; ulps_req = 0; data_stop = 1; rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 in reset", Y_STOP);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", Y_STOP);
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic burst(int lpx, int prep, int zero, int pre, int post, int trail, string tag);
    run_req = 1;
    expect_run(Y_LP01, lpx, {tag, " R2 LP-01"});
    expect_run(Y_LP00, prep, {tag, " R2 LP-00"});
    expect_run(Y_HS0, zero, {tag, " R2 HS-0"});
    expect_run(Y_TOG, pre, {tag, " R3 pre"});
    expect_run(Y_GRANT, 1, {tag, " R3 grant"});
    data_stop = 0;
    expect_run(Y_GRANT, 3, {tag, " R3 grant held"});
    run_req = 0;
    expect_run(Y_GRANT, 2, {tag, " R5 busy data lane"});
    data_stop = 1;
    expect_run(Y_TOG, post, {tag, " R4 post"});
    expect_run(Y_HS0, trail, {tag, " R4 trail"});
    expect_run(Y_STOP, 2, {tag, " R4 stop"});
  endtask

  initial begin
    do_reset(1, 1, 1, 1, 1, 1, 1);
    for (int a = 1; a <= 3; a++)
      for (int b = 1; b <= 2; b++)
        for (int c = 1; c <= 3; c++)
          for (int d = 1; d <= 2; d++)
            for (int e = 1; e <= 2; e++)
              for (int f = 1; f <= 2; f++) begin
                do_reset(a, b, c, d, e, f, 1);
                burst(a, b, c, d, e, f, "sweep");
              end

    do_reset(2, 3, 1, 2, 3, 1, 1);
    cfg_lpx = 7; cfg_prep = 7; cfg_zero = 7; cfg_pre = 7; cfg_post = 7; cfg_trail = 7;
    burst(2, 3, 1, 2, 3, 1, "R10 cfg change ignored");

    do_reset(0, 0, 0, 0, 0, 0, 0);
    burst(eff(0), eff(0), eff(0), eff(0), eff(0), eff(0), "R11 zero counts");

    for (int a = 1; a <= 3; a++)
      for (int w = 0; w <= 4; w++) begin
        do_reset(a, 1, 1, 1, 1, 1, w);
        ulps_req = 1;
        expect_run(Y_LP10, a, "R6 entry LP-10");
        expect_run(Y_ULPS, 2, "R6 parked");
        run_req = 1;
        expect_run(Y_ULPS, 4, "R8 request held");
        ulps_req = 0;
        expect_run(Y_LP10, eff(w), "R7 wake LP-10");
        expect_run(Y_STOP, 1, "R8 stop one cycle");
        expect_run(Y_LP01, a, "R8 start LP-01");
        expect_run(Y_LP00, 1, "R8 LP-00");
        expect_run(Y_HS0, 1, "R8 HS-0");
        expect_run(Y_TOG, 1, "R8 pre");
        expect_run(Y_GRANT, 1, "R8 grant");
        run_req = 0;
        expect_run(Y_TOG, 1, "R4 post");
        expect_run(Y_HS0, 1, "R4 trail");
        expect_run(Y_STOP, 2, "R4 stop");
      end

    do_reset(2, 1, 2, 1, 1, 1, 1);
    run_req = 1; ulps_req = 1;
    expect_run(Y_LP01, 1, "R9 start wins");
    ulps_req = 0;
    expect_run(Y_LP01, 1, "R9 LP-01");
    expect_run(Y_LP00, 1, "R9 LP-00");
    expect_run(Y_HS0, 2, "R9 HS-0");
    expect_run(Y_TOG, 1, "R9 pre");
    expect_run(Y_GRANT, 1, "R9 grant");
    run_req = 0;
    expect_run(Y_TOG, 1, "R4 post");
    expect_run(Y_HS0, 1, "R4 trail");
    expect_run(Y_STOP, 2, "R4 stop");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule